// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Memory Write Controller

This block is the control logic for a byte-wide non-volatile store that is programmed one page at a time. A host drives a parallel bus with active-low chip select, read enable and write enable, a 16-bit address and an 8-bit data bus, all sampled in the system clock domain. Each write strobe latches address and data into a 128-byte page register. The host needs to hold neither after the strobe. When no further write arrives within a load window, a self-timed commit copies the gathered bytes into the storage array, which is modelled as an inferred RAM.

While the commit runs, a read does not return array data. It returns a status byte. Bit 7 is the complement of bit 7 of the last byte loaded, and bit 6 flips on every new read access. Software polls either bit to find out when the commit has finished. Writes are gated in hardware by a power-good input and by the read enable. A software lock, set and cleared by three-write key sequences, also gates writes.

The array holds `2**(IDX_W+ROW_W)` bytes. The default has 16 page rows, and `ROW_W = 9` gives the full 64K x 8 organisation. Address bits above the array size alias. The load window (`LOAD_WIN`) and the commit duration (`COMMIT_CYC`) are counted in clock cycles. Their defaults correspond to 150 us and 5 ms at 250 MHz. `COMMIT_CYC` must exceed the page size.

Top module: `pgw_ctrl`

## Requirements
- R1: After synchronous reset, `rdata` is 0, `rdata_vld` is 0, no commit is pending and the software lock is off.
- R2: A read is active in any cycle where `chip_sel_n` and `rd_en_n` are both low. In the next cycle `rdata_vld` is 1. If no commit is running, `rdata` then holds the array byte at `addr` modulo the array size. In the cycle after an inactive read cycle, both outputs are 0.
- R3: A write strobe is the first cycle in which `chip_sel_n` and `wr_en_n` are both low. It loads `wdata` into page slot `addr[6:0]`, and a later write to the same slot replaces it. The commit targets the page row given by `addr[15:7]` (modulo the row count) of the last loaded byte. Any number of bytes from 1 to 128 may be loaded.
- R4: The commit begins exactly `LOAD_WIN` cycles after the strobe cycle of the last loaded byte. Each loaded byte restarts the window. Until the commit begins, reads return array data.
- R5: A commit lasts `COMMIT_CYC` cycles. Afterwards the array holds every loaded byte at its slot, all other bytes of the row are unchanged, and the page register is empty. Write strobes during a commit are ignored.
- R6: During a commit, read data bit 7 is the inverse of bit 7 of the last loaded byte. After the commit, reads return the true data.
- R7: During a commit, read data bit 6 starts at 0 and inverts on each new read access (a read cycle not preceded by a read cycle). Bits 5:0 read as 0.
- R8: A write strobe is ignored while `pwr_good` is low or `rd_en_n` is low.
- R9: The key sequence 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555 turns the software lock on. It also admits the bytes written after it until the next commit ends. When the lock was off, the three key writes are loaded as ordinary bytes.
- R10: While the lock is on, a write not preceded by the sequence of R9 within the current load is ignored.
- R11: The key sequence 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555 turns the lock off. Key writes issued while the lock is on are not loaded.
- R12: A write that does not match the next expected key step abandons the sequence. A write of 0xAA at 0x5555 always restarts the sequence at step one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good indication; low blocks writes |
| chip_sel_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low read (output) enable |
| wr_en_n | input | 1 | Active-low write strobe |
| addr | input | 16 | Byte address; bits 6:0 slot, upper bits page row |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or commit status, one cycle after the read cycle |
| rdata_vld | output | 1 | High in the cycle after a read cycle |

## Verification
The hardest situation to reach from the ports is a protected load: the lock must already be on, and then a complete key sequence must arrive with no stray write in between. Only after that may data be loaded, and the unlock must expire at the end of the commit. The stimulus first turns the lock on from the unlocked state, where the key writes are loaded as data. It then drives a plain write, a broken sequence and a valid sequence. Each is followed by a read-back after the full window plus commit time, so that an accepted or ignored byte shows up at `rdata`. The bench also places reads at exact cycle offsets from the last strobe, which catches an off-by-one in the load window.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2
    } pgw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pgw_wr_t;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_LOCK   = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_UNLOCK = 8'h20;

    function automatic logic key_hit(input pgw_wr_t w,
                                     input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

    function automatic logic [DATA_W-1:0] poll_byte(input logic last_msb,
                                                    input logic tog);
        return {~last_msb, tog, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/pgw_protect.sv
`timescale 1ns/1ps
module pgw_protect
    import pgw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_stb,
    input  pgw_wr_t cmd,
    input  logic    unl_clr,
    output logic    prot,
    output logic    unl
);

    typedef enum logic [1:0] {SQ_NONE, SQ_ONE, SQ_TWO} sq_e;
    sq_e  sq_q;
    logic first_hit;

    assign first_hit = key_hit(cmd, KEY_ADDR_A, KEY_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q <= SQ_NONE;
            prot <= 1'b0;
            unl  <= 1'b0;
        end else begin
            if (unl_clr) unl <= 1'b0;
            if (cmd_stb) begin
                unique case (sq_q)
                    SQ_ONE: begin
                        if (key_hit(cmd, KEY_ADDR_B, KEY_SECOND)) sq_q <= SQ_TWO;
                        else if (first_hit)                       sq_q <= SQ_ONE;
                        else                                      sq_q <= SQ_NONE;
                    end
                    SQ_TWO: begin
                        sq_q <= first_hit ? SQ_ONE : SQ_NONE;
                        if (key_hit(cmd, KEY_ADDR_A, KEY_LOCK)) begin
                            prot <= 1'b1;
                            unl  <= 1'b1;
                        end
                        if (key_hit(cmd, KEY_ADDR_A, KEY_UNLOCK)) prot <= 1'b0;
                    end
                    default: sq_q <= first_hit ? SQ_ONE : SQ_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pgw_pagereg.sv
`timescale 1ns/1ps
module pgw_pagereg
    import pgw_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int ROW_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_vld,
    output logic [ROW_W-1:0]  row,
    output logic              last_msb,
    output logic              any_vld
);

    localparam int PAGE = 1 << IDX_W;

    logic [DATA_W-1:0] slot_q [PAGE];
    logic [PAGE-1:0]   vld_q;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic hit;
        assign hit = ld && (ld_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (hit) slot_q[g] <= ld_data;
        end

        always_ff @(posedge clk) begin
            if (rst || clr) vld_q[g] <= 1'b0;
            else if (hit)   vld_q[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row      <= '0;
            last_msb <= 1'b0;
        end else if (ld) begin
            row      <= ld_row;
            last_msb <= ld_data[DATA_W-1];
        end
    end

    assign rd_byte = slot_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;

endmodule

// File: rtl/pgw_array.sv
`timescale 1ns/1ps
module pgw_array
    import pgw_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pgw_ctrl.sv
`timescale 1ns/1ps
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int IDX_W      = 7,
    parameter int ROW_W      = 4,
    parameter int LOAD_WIN   = 37500,
    parameter int COMMIT_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              chip_sel_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    localparam int PAGE = 1 << IDX_W;
    localparam int AW   = IDX_W + ROW_W;
    localparam int TW   = $clog2(LOAD_WIN);
    localparam int CW   = $clog2(COMMIT_CYC);

    pgw_state_e st_q;
    logic [TW-1:0] tmr_q;
    logic [CW-1:0] ccnt_q;

    logic rd_act, wr_act, rd_act_q, wr_act_q;
    logic wr_stb, wr_open, ld;
    logic prot, unl;
    logic in_commit, commit_end, commit_we;
    logic tog_q;
    pgw_wr_t cmd;

    logic [DATA_W-1:0] pg_byte, arr_rdata;
    logic              pg_slot_vld, pg_last_msb, pg_any;
    logic [ROW_W-1:0]  pg_row;

    // Bus sampling and strobe detection
    assign rd_act = ~chip_sel_n & ~rd_en_n;
    assign wr_act = ~chip_sel_n & ~wr_en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
        end
    end

    assign in_commit = (st_q == ST_COMMIT);
    assign wr_stb    = wr_act & ~wr_act_q;
    assign wr_open   = wr_stb & pwr_good & rd_en_n & ~in_commit;
    assign ld        = wr_open & (~prot | unl);
    assign cmd       = '{addr: addr, data: wdata};

    // Software lock sequencer
    pgw_protect u_protect (
        .clk     (clk),
        .rst     (rst),
        .cmd_stb (wr_open),
        .cmd     (cmd),
        .unl_clr (commit_end),
        .prot    (prot),
        .unl     (unl)
    );

    // Page register
    pgw_pagereg #(.IDX_W(IDX_W), .ROW_W(ROW_W)) u_pagereg (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .ld_idx   (addr[IDX_W-1:0]),
        .ld_row   (addr[IDX_W +: ROW_W]),
        .ld_data  (wdata),
        .clr      (commit_end),
        .rd_idx   (ccnt_q[IDX_W-1:0]),
        .rd_byte  (pg_byte),
        .rd_vld   (pg_slot_vld),
        .row      (pg_row),
        .last_msb (pg_last_msb),
        .any_vld  (pg_any)
    );

    // Load window and commit sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            ccnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (ld) begin
                        st_q  <= ST_LOAD;
                        tmr_q <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ld) begin
                        tmr_q <= '0;
                    end else if (tmr_q == TW'(LOAD_WIN - 1)) begin
                        st_q   <= ST_COMMIT;
                        ccnt_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    if (commit_end) st_q <= ST_IDLE;
                    else            ccnt_q <= ccnt_q + 1'b1;
                end
            endcase
        end
    end

    assign commit_end = in_commit && (ccnt_q == CW'(COMMIT_CYC - 1));
    assign commit_we  = in_commit && (ccnt_q < CW'(PAGE)) && pg_slot_vld;

    // Storage array
    pgw_array #(.AW(AW)) u_array (
        .clk   (clk),
        .we    (commit_we),
        .waddr ({pg_row, ccnt_q[IDX_W-1:0]}),
        .wdata (pg_byte),
        .raddr (addr[AW-1:0]),
        .rdata (arr_rdata)
    );

    // Toggle status bit: flips per new read access during a commit
    always_ff @(posedge clk) begin
        if (rst || !in_commit)          tog_q <= 1'b0;
        else if (rd_act && !rd_act_q)   tog_q <= ~tog_q;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= rd_act;
            if (!rd_act)        rdata <= '0;
            else if (in_commit) rdata <= poll_byte(pg_last_msb, tog_q);
            else                rdata <= arr_rdata;
        end
    end

endmodule

// File: rtl/pgw_ctrl_chk.sv
`timescale 1ns/1ps
module pgw_ctrl_chk
    import pgw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic              chip_sel_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld,
    input pgw_state_e        st,
    input logic              any_vld,
    input logic              last_msb,
    input logic              tog
);

    logic rd;
    assign rd = ~chip_sel_n & ~rd_en_n;

    assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rd |=> rdata_vld);

    assert_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (!rdata_vld && rdata == '0));

    assert_commit_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_COMMIT) |-> any_vld);

    assert_commit_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(st == ST_COMMIT) |-> !any_vld);

    assert_poll_msb_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COMMIT && rd) |=> (rdata[DATA_W-1] == !last_msb));

    assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COMMIT && $rose(rd)) |=> (tog != $past(tog)));

    assert_power_block_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !pwr_good) |=> (st == ST_IDLE));

endmodule

bind pgw_ctrl pgw_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_good   (pwr_good),
    .chip_sel_n (chip_sel_n),
    .rd_en_n    (rd_en_n),
    .rdata      (rdata),
    .rdata_vld  (rdata_vld),
    .st         (st_q),
    .any_vld    (pg_any),
    .last_msb   (pg_last_msb),
    .tog        (tog_q)
);

// File: tb/pgw_ctrl_tb.sv
`timescale 1ns/1ps
module pgw_ctrl_tb;
    import pgw_pkg::*;

    localparam int IDX_W = 7;
    localparam int ROW_W = 4;
    localparam int LW    = 16;
    localparam int CC    = 140;
    localparam int PAGE  = 1 << IDX_W;
    localparam int ARR   = PAGE << ROW_W;
    localparam int WDOG  = 150000;

    logic clk = 1'b0, rst = 1'b1, pwr_good = 1'b1;
    logic chip_sel_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_vld;

    always #2 clk = ~clk;

    pgw_ctrl #(.IDX_W(IDX_W), .ROW_W(ROW_W), .LOAD_WIN(LW), .COMMIT_CYC(CC)) u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .chip_sel_n(chip_sel_n),
        .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int n_chk = 0, n_fail = 0, n_cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference model
    logic [7:0] m_mem [ARR];
    bit         m_known [ARR];
    logic [7:0] m_pb [PAGE];
    bit         m_pv [PAGE];
    int  m_st = 0, m_tmr = 0, m_cc = 0, m_row = 0, m_seq = 0;
    bit  m_prot = 0, m_unl = 0, m_tog = 0, m_last7 = 0;
    bit  m_prev_rd = 0, m_prev_wr = 0;
    logic [7:0] m_exp = '0;
    bit  m_exp_oe = 0, m_exp_chk = 1;

    initial begin
        for (int i = 0; i < ARR; i++) m_known[i] = 1'b0;
        for (int i = 0; i < PAGE; i++) m_pv[i] = 1'b0;
    end

    always @(posedge clk) begin
        bit rd, wr, stb, acc, a1, b2;
        int ai;
        if (rst) begin
            m_st = 0; m_tmr = 0; m_cc = 0; m_seq = 0; m_row = 0;
            m_prot = 0; m_unl = 0; m_tog = 0; m_last7 = 0;
            m_prev_rd = 0; m_prev_wr = 0;
            m_exp = '0; m_exp_oe = 0; m_exp_chk = 1;
            for (int i = 0; i < PAGE; i++) m_pv[i] = 1'b0;
        end else begin
            rd  = !chip_sel_n && !rd_en_n;
            wr  = !chip_sel_n && !wr_en_n;
            stb = wr && !m_prev_wr;
            m_exp_oe  = rd;
            m_exp_chk = 1;
            if (!rd) m_exp = '0;
            else if (m_st == 2) m_exp = {~m_last7, m_tog, 6'b0};
            else begin
                ai = int'(addr) % ARR;
                m_exp = m_mem[ai];
                m_exp_chk = m_known[ai];
            end
            if (m_st == 2 && rd && !m_prev_rd) m_tog = !m_tog;

            if (m_st == 2) begin
                if (m_cc < PAGE && m_pv[m_cc]) begin
                    m_mem[m_row*PAGE + m_cc]   = m_pb[m_cc];
                    m_known[m_row*PAGE + m_cc] = 1'b1;
                end
                if (m_cc == CC-1) begin
                    m_st = 0; m_unl = 0;
                    for (int i = 0; i < PAGE; i++) m_pv[i] = 1'b0;
                end else m_cc++;
            end else begin
                acc = 0;
                if (stb && pwr_good && rd_en_n) begin
                    acc = !m_prot || m_unl;
                    a1 = (addr == 16'h5555) && (wdata == 8'hAA);
                    b2 = (addr == 16'h2AAA) && (wdata == 8'h55);
                    if (m_seq == 2) begin
                        if (addr == 16'h5555 && wdata == 8'hA0) begin m_prot = 1; m_unl = 1; end
                        if (addr == 16'h5555 && wdata == 8'h20) m_prot = 0;
                        m_seq = a1 ? 1 : 0;
                    end else if (m_seq == 1) m_seq = b2 ? 2 : (a1 ? 1 : 0);
                    else m_seq = a1 ? 1 : 0;
                    if (acc) begin
                        m_pb[int'(addr) % PAGE] = wdata;
                        m_pv[int'(addr) % PAGE] = 1'b1;
                        m_row   = (int'(addr) / PAGE) % (ARR / PAGE);
                        m_last7 = wdata[7];
                        m_st  = 1;
                        m_tmr = 0;
                    end
                end
                if (!acc && m_st == 1) begin
                    if (m_tmr == LW-1) begin m_st = 2; m_cc = 0; m_tog = 0; end
                    else m_tmr++;
                end
            end
            m_prev_rd = rd;
            m_prev_wr = wr;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (rdata_vld !== m_exp_oe) begin
                n_fail++;
                $display("FAIL %s: rdata_vld=%0b expected %0b", cur_req, rdata_vld, m_exp_oe);
            end
            n_chk++;
            if (m_exp_chk && rdata !== m_exp) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected %02h", cur_req, rdata, m_exp);
            end
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > WDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", n_cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; chip_sel_n = 1'b0; wr_en_n = 1'b0;
        @(negedge clk);
        wr_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic wr_with_oe(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; chip_sel_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0;
        @(negedge clk);
        wr_en_n = 1'b1; rd_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [15:0] a);
        @(negedge clk);
        addr = a; chip_sel_n = 1'b0; rd_en_n = 1'b0;
        @(negedge clk);
        rd_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic settle();
        cyc(LW + CC + 6);
    endtask

    initial begin
        cyc(4);
        cur_req = "R1";
        n_chk++;
        if (rdata !== 8'h00 || rdata_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rdata=%02h vld=%0b expected 00/0", rdata, rdata_vld);
        end
        rst = 1'b0;
        cyc(2);

        // R3/R4: partial page load into row 3
        cur_req = "R3";
        for (int i = 0; i < 16; i++) wr_byte(16'h0180 + 16'(i), 8'(i*7 + 1));
        cur_req = "R4";
        cyc(LW - 4);
        rd_byte(16'h0180);
        // R6/R7: status polling during commit
        cur_req = "R6";
        cyc(4);
        rd_byte(16'h0180);
        cur_req = "R7";
        for (int i = 0; i < 4; i++) rd_byte(16'h0181);
        cyc(CC);
        // R2/R5: read back committed bytes
        cur_req = "R2";
        for (int i = 0; i < 16; i++) rd_byte(16'h0180 + 16'(i));

        // R4: window restarts with each byte
        cur_req = "R4";
        wr_byte(16'h0280, 8'h81);
        cyc(LW - 3);
        wr_byte(16'h0281, 8'h12);
        cyc(LW - 3);
        rd_byte(16'h0180);
        wr_byte(16'h0282, 8'hF3);
        settle();
        for (int i = 0; i < 3; i++) rd_byte(16'h0280 + 16'(i));

        // R3: overwrite of a slot, row taken from last byte
        cur_req = "R3";
        wr_byte(16'h0305, 8'h11);
        wr_byte(16'h0305, 8'h22);
        wr_byte(16'h0386, 8'h33);
        settle();
        rd_byte(16'h0385);
        rd_byte(16'h0386);

        // R3: full 128-byte page
        for (int i = 0; i < PAGE; i++) wr_byte(16'h0080 + 16'(i), 8'(255 - i));
        settle();
        for (int i = 0; i < PAGE; i += 9) rd_byte(16'h0080 + 16'(i));

        // R5: writes during commit are ignored
        cur_req = "R5";
        wr_byte(16'h0100, 8'h5A);
        cyc(LW + 3);
        wr_byte(16'h0180, 8'hEE);
        rd_byte(16'h0180);
        settle();
        rd_byte(16'h0180);
        rd_byte(16'h0100);

        // R8: power-good low and read enable low block writes
        cur_req = "R8";
        pwr_good = 1'b0;
        wr_byte(16'h0181, 8'hC4);
        pwr_good = 1'b1;
        wr_with_oe(16'h0182, 8'hC5);
        settle();
        rd_byte(16'h0181);
        rd_byte(16'h0182);

        // R9: lock on from unlocked state, key bytes and data stored
        cur_req = "R9";
        wr_byte(16'h5555, 8'hAA);
        wr_byte(16'h2AAA, 8'h55);
        wr_byte(16'h5555, 8'hA0);
        for (int i = 0; i < 4; i++) wr_byte(16'h0200 + 16'(i), 8'(8'h40 + i));
        settle();
        for (int i = 0; i < 4; i++) rd_byte(16'h0200 + 16'(i));
        rd_byte(16'h0255);

        // R10: plain write while locked is ignored
        cur_req = "R10";
        wr_byte(16'h0200, 8'h99);
        settle();
        rd_byte(16'h0200);

        // R12: broken key sequence does not unlock
        cur_req = "R12";
        wr_byte(16'h5555, 8'hAA);
        wr_byte(16'h1234, 8'h11);
        wr_byte(16'h5555, 8'hA0);
        wr_byte(16'h0201, 8'h98);
        settle();
        rd_byte(16'h0201);

        // R9: valid sequence while locked admits data
        cur_req = "R9";
        wr_byte(16'h5555, 8'hAA);
        wr_byte(16'h5555, 8'hAA);
        wr_byte(16'h2AAA, 8'h55);
        wr_byte(16'h5555, 8'hA0);
        wr_byte(16'h0202, 8'h3C);
        settle();
        rd_byte(16'h0202);
        cur_req = "R10";
        wr_byte(16'h0203, 8'h77);
        settle();
        rd_byte(16'h0203);

        // R11: unlock sequence, then plain writes land
        cur_req = "R11";
        wr_byte(16'h5555, 8'hAA);
        wr_byte(16'h2AAA, 8'h55);
        wr_byte(16'h5555, 8'h20);
        wr_byte(16'h0203, 8'h6D);
        settle();
        rd_byte(16'h0203);
        rd_byte(16'h0255);

        cyc(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule